// File: doc/BRIEF.md
# Stream Cipher Frame Sequencer

This block drives a bit-serial keystream generator built from three majority-stepped shift registers. The generator core is outside the block. For one frame session, the sequencer issues the core's 3-bit control word on every cycle. It also reads back the core's single keystream bit and packs the useful part of it into two burst words, one for each link direction.

A single-cycle `start_i` begins a session. On that pulse the block latches the 64-bit session key and the 22-bit frame number. The session then runs this fixed schedule:

- one reset cycle;
- 64 forced key-load cycles;
- 22 forced frame-load cycles;
- 100 discarded mixing cycles, in which the core steps under its majority rule;
- 114 cycles of the first burst;
- 114 cycles of the second burst, with no gap after the first.

The core updates on the clock edge that ends a control cycle. For that reason a keystream bit is taken from `ks_i` one cycle after the control cycle that produced it, and a single tail cycle follows the last burst cycle.

The control states, in order, are IDLE, RESET, KEY, FRAME, MIX, BURST_A, BURST_B and TAIL. The transitions are:

- IDLE→RESET on an accepted start.
- RESET→KEY after one cycle.
- KEY→FRAME after the last key bit.
- FRAME→MIX after the last frame bit.
- MIX→BURST_A after the last mixing cycle.
- BURST_A→BURST_B after 114 cycles.
- BURST_B→TAIL after 114 cycles.
- TAIL→IDLE after one cycle, which also raises done.

Top module: `keystream_frame_seq`

## Requirements
- R1: The control word uses bit 0 for serial load data, bit 1 for force-stepping all core registers, and bit 2 for a synchronous core reset. While `rst_n` is low, and in IDLE, the control word is 000 and both `busy_o` and `done_o` are low. Asserting `rst_n` low in the middle of a session returns the block to this state.
- R2: A start pulse seen in IDLE latches `key_i` and `frame_i`. `busy_o` rises in the next cycle and stays low in the cycle of the pulse.
- R3: The first session cycle drives control word 100, and it does so for exactly one cycle.
- R4: The next 64 cycles drive {0, 1, key[i]} for i = 0 up to 63, lowest bit first.
- R5: The next 22 cycles drive {0, 1, frame[i]} for i = 0 up to 21, lowest bit first.
- R6: The next 100 cycles drive 000. Keystream seen during them is not stored.
- R7: The next 114 cycles drive 000. The `ks_i` value in the cycle after each of them is shifted into `word_a_o` at bit 0, so the earliest bit ends in bit 113.
- R8: The second burst follows at once with 114 more 000 cycles, and it fills `word_b_o` in the same way.
- R9: `busy_o` stays high for 416 cycles: 415 schedule cycles plus the tail cycle. In the next cycle `done_o` is high for one cycle and `busy_o` is low.
- R10: A start pulse, or any change on `key_i` or `frame_i`, while `busy_o` is high has no effect on the schedule or its results. Both words hold their values while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Session start pulse |
| key_i | input | 64 | Session key |
| frame_i | input | 22 | Frame number |
| ks_i | input | 1 | Keystream bit from the core |
| ctrl_o | output | 3 | Core control word {reset, force, data} |
| word_a_o | output | 114 | First-direction burst word |
| word_b_o | output | 114 | Second-direction burst word |
| busy_o | output | 1 | Session in progress |
| done_o | output | 1 | One-cycle pulse when both words are complete |

## Verification
The assertions assume that `start_i` may arrive at any time, and that only its value in IDLE counts. They also assume that `ks_i` reflects the core state after the edge that ended the previous control cycle. The bench meets both assumptions by clocking a behavioural three-register core model from the block's own control word. It changes `start_i`, `key_i` and `frame_i` only 2 ns after a rising edge, including a deliberate extra start and an altered key and frame in the middle of a session. A scoreboard holds the expected control word, busy and done values for each cycle, and the monitor pops one entry per falling edge.

// File: rtl/kfs_pkg.sv
`timescale 1ns/1ps
package kfs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESET,
        ST_KEY,
        ST_FRAME,
        ST_MIX,
        ST_BURST_A,
        ST_BURST_B,
        ST_TAIL
    } seq_state_t;

    localparam int CTL_DATA  = 0;
    localparam int CTL_FORCE = 1;
    localparam int CTL_RESET = 2;
    localparam int CTL_W     = 3;
endpackage

// File: rtl/kfs_phase_fsm.sv
`timescale 1ns/1ps
module kfs_phase_fsm
    import kfs_pkg::*;
#(
    parameter int KEY_W   = 64,
    parameter int FRAME_W = 22,
    parameter int MIX_CYC = 100,
    parameter int BURST_W = 114,
    parameter int CNT_W   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output seq_state_t       state_o,
    output logic [CNT_W-1:0] idx_o,
    output logic             accept_o,
    output logic             busy_o,
    output logic             done_o
);
    seq_state_t       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             last_beat;
    logic             done_q;

    // Next state and beat counter
    always_comb begin
        last_beat = 1'b0;
        unique case (st_q)
            ST_KEY:                 last_beat = (cnt_q == CNT_W'(KEY_W - 1));
            ST_FRAME:               last_beat = (cnt_q == CNT_W'(FRAME_W - 1));
            ST_MIX:                 last_beat = (cnt_q == CNT_W'(MIX_CYC - 1));
            ST_BURST_A, ST_BURST_B: last_beat = (cnt_q == CNT_W'(BURST_W - 1));
            default:                last_beat = 1'b1;
        endcase

        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (start_i) st_d = ST_RESET;
            ST_RESET:   st_d = ST_KEY;
            ST_KEY:     if (last_beat) st_d = ST_FRAME;
            ST_FRAME:   if (last_beat) st_d = ST_MIX;
            ST_MIX:     if (last_beat) st_d = ST_BURST_A;
            ST_BURST_A: if (last_beat) st_d = ST_BURST_B;
            ST_BURST_B: if (last_beat) st_d = ST_TAIL;
            ST_TAIL:    st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase

        if ((st_d != st_q) || (st_q == ST_IDLE)) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            done_q <= (st_q == ST_TAIL);
        end
    end

    // Outputs
    always_comb begin
        state_o  = st_q;
        idx_o    = cnt_q;
        busy_o   = (st_q != ST_IDLE);
        accept_o = (st_q == ST_IDLE) && start_i;
        done_o   = done_q;
    end

    // R3
    reset_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RESET) |=> (st_q == ST_KEY));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    done_after_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(st_q) == ST_TAIL) && !busy_o);

    // R10
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q != ST_IDLE) && start_i) |=> (st_q != ST_RESET));
endmodule

// File: rtl/kfs_ctrl_gen.sv
`timescale 1ns/1ps
module kfs_ctrl_gen
    import kfs_pkg::*;
#(
    parameter int KEY_W   = 64,
    parameter int FRAME_W = 22,
    parameter int CNT_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  seq_state_t         state_i,
    input  logic [CNT_W-1:0]   idx_i,
    input  logic [KEY_W-1:0]   key_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic [CTL_W-1:0]   ctrl_o
);
    localparam int KEY_IW   = $clog2(KEY_W);
    localparam int FRAME_IW = $clog2(FRAME_W);

    logic key_bit, frame_bit;

    always_comb begin
        key_bit   = key_i[idx_i[KEY_IW-1:0]];
        frame_bit = frame_i[idx_i[FRAME_IW-1:0]];
        ctrl_o    = '0;
        unique case (state_i)
            ST_RESET: ctrl_o[CTL_RESET] = 1'b1;
            ST_KEY: begin
                ctrl_o[CTL_FORCE] = 1'b1;
                ctrl_o[CTL_DATA]  = key_bit;
            end
            ST_FRAME: begin
                ctrl_o[CTL_FORCE] = 1'b1;
                ctrl_o[CTL_DATA]  = frame_bit;
            end
            default: ctrl_o = '0;
        endcase
    end

    // R1
    idle_ctl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_IDLE) |-> (ctrl_o == '0));

    // R6
    data_needs_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_o[CTL_FORCE] |-> !ctrl_o[CTL_DATA]);

    // R3
    reset_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o[CTL_RESET] |=> !ctrl_o[CTL_RESET]);
endmodule

// File: rtl/kfs_burst_collect.sv
`timescale 1ns/1ps
module kfs_burst_collect
    import kfs_pkg::*;
#(
    parameter int BURST_W = 114
) (
    input  logic               clk,
    input  logic               rst_n,
    input  seq_state_t         state_i,
    input  logic               ks_i,
    output logic [BURST_W-1:0] word_a_o,
    output logic [BURST_W-1:0] word_b_o
);
    logic cap_a_q, cap_b_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_a_q  <= 1'b0;
            cap_b_q  <= 1'b0;
            word_a_o <= '0;
            word_b_o <= '0;
        end else begin
            cap_a_q <= (state_i == ST_BURST_A);
            cap_b_q <= (state_i == ST_BURST_B);
            if (cap_a_q) word_a_o <= {word_a_o[BURST_W-2:0], ks_i};
            if (cap_b_q) word_b_o <= {word_b_o[BURST_W-2:0], ks_i};
        end
    end

    // R8
    burst_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_b_q) |-> $past(cap_a_q));
endmodule

// File: rtl/keystream_frame_seq.sv
`timescale 1ns/1ps
module keystream_frame_seq
    import kfs_pkg::*;
#(
    parameter int KEY_W   = 64,
    parameter int FRAME_W = 22,
    parameter int MIX_CYC = 100,
    parameter int BURST_W = 114
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [KEY_W-1:0]   key_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               ks_i,
    output logic [CTL_W-1:0]   ctrl_o,
    output logic [BURST_W-1:0] word_a_o,
    output logic [BURST_W-1:0] word_b_o,
    output logic               busy_o,
    output logic               done_o
);
    localparam int LEN_A   = (KEY_W > FRAME_W) ? KEY_W : FRAME_W;
    localparam int LEN_B   = (MIX_CYC > BURST_W) ? MIX_CYC : BURST_W;
    localparam int MAX_LEN = (LEN_A > LEN_B) ? LEN_A : LEN_B;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    seq_state_t         state;
    logic [CNT_W-1:0]   idx;
    logic               accept;
    logic [KEY_W-1:0]   key_q;
    logic [FRAME_W-1:0] frame_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q   <= '0;
            frame_q <= '0;
        end else if (accept) begin
            key_q   <= key_i;
            frame_q <= frame_i;
        end
    end

    kfs_phase_fsm #(
        .KEY_W(KEY_W), .FRAME_W(FRAME_W), .MIX_CYC(MIX_CYC),
        .BURST_W(BURST_W), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .state_o(state), .idx_o(idx), .accept_o(accept),
        .busy_o(busy_o), .done_o(done_o)
    );

    kfs_ctrl_gen #(
        .KEY_W(KEY_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .state_i(state), .idx_i(idx),
        .key_i(key_q), .frame_i(frame_q), .ctrl_o(ctrl_o)
    );

    kfs_burst_collect #(
        .BURST_W(BURST_W)
    ) u_collect (
        .clk(clk), .rst_n(rst_n), .state_i(state), .ks_i(ks_i),
        .word_a_o(word_a_o), .word_b_o(word_b_o)
    );

    // R10
    key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(key_q) && $stable(frame_q)));

    // R10
    words_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> ($stable(word_a_o) && $stable(word_b_o)));

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy_o);
endmodule

// File: tb/keystream_frame_seq_bench.sv
`timescale 1ns/1ps
module keystream_frame_seq_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [63:0]  key_i = '0;
    logic [21:0]  frame_i = '0;
    logic         ks;
    logic [2:0]   ctrl;
    logic [113:0] word_a, word_b;
    logic         busy, done;

    int total = 0;
    int bad = 0;
    bit reported = 0;

    always #4 clk = ~clk;

    keystream_frame_seq u_keystream_frame_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .key_i(key_i),
        .frame_i(frame_i), .ks_i(ks), .ctrl_o(ctrl), .word_a_o(word_a),
        .word_b_o(word_b), .busy_o(busy), .done_o(done)
    );

    // Behavioural keystream core driven by the control word
    logic [18:0] ra = '0;
    logic [21:0] rb = '0;
    logic [22:0] rc = '0;
    logic        maj;
    always_comb begin
        maj = (ra[8] & rb[10]) | (ra[8] & rc[10]) | (rb[10] & rc[10]);
        ks  = ra[18] ^ rb[21] ^ rc[22];
    end
    always @(posedge clk) begin
        if (ctrl[2]) begin
            ra <= '0; rb <= '0; rc <= '0;
        end else begin
            if (ctrl[1] || ra[8] == maj) ra <= {ra[17:0], ctrl[0] ^ ra[13] ^ ra[16] ^ ra[17] ^ ra[18]};
            if (ctrl[1] || rb[10] == maj) rb <= {rb[20:0], ctrl[0] ^ rb[20] ^ rb[21]};
            if (ctrl[1] || rc[10] == maj) rc <= {rc[21:0], ctrl[0] ^ rc[7] ^ rc[20] ^ rc[21] ^ rc[22]};
        end
    end

    typedef struct {
        logic [2:0] ctl;
        logic       busy;
        logic       done;
        logic [1:0] cap;
        logic       words;
        string      tag;
    } sb_item_t;

    sb_item_t     sb_q[$];
    logic [113:0] exp_a = '0;
    logic [113:0] exp_b = '0;

    task automatic check_vec(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
        end
    endtask

    // Monitor: pops one expected item per cycle
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t e;
            e = sb_q.pop_front();
            check_vec(e.tag, {125'd0, ctrl}, {125'd0, e.ctl});
            check_vec(e.tag, {127'd0, busy}, {127'd0, e.busy});
            check_vec("R9", {127'd0, done}, {127'd0, e.done});
            if (e.cap == 2'd1) exp_a = {exp_a[112:0], ks};
            if (e.cap == 2'd2) exp_b = {exp_b[112:0], ks};
            if (e.words) begin
                check_vec("R7", {14'd0, word_a}, {14'd0, exp_a});
                check_vec("R8", {14'd0, word_b}, {14'd0, exp_b});
            end
        end
    end

    // Driver: pushes the whole expected schedule, then launches the session
    task automatic run_session(input logic [63:0] key, input logic [21:0] frame, input bit disturb);
        @(posedge clk); #2;
        key_i   = key;
        frame_i = frame;
        start_i = 1'b1;
        for (int j = 0; j < 419; j++) begin
            sb_item_t e;
            e.ctl = 3'b000; e.busy = (j >= 1 && j <= 416); e.done = (j == 417);
            e.cap = 2'd0; e.words = (j == 417); e.tag = "R9";
            if (j == 0) e.tag = "R2";
            else if (j == 1) begin e.ctl = 3'b100; e.tag = "R3"; end
            else if (j <= 65) begin e.ctl = {2'b01, key[j-2]}; e.tag = "R4"; end
            else if (j <= 87) begin e.ctl = {2'b01, frame[j-66]}; e.tag = "R5"; end
            else if (j <= 187) e.tag = "R6";
            else if (j <= 301) e.tag = "R7";
            else if (j <= 415) e.tag = "R8";
            if (j >= 189 && j <= 302) e.cap = 2'd1;
            if (j >= 303 && j <= 416) e.cap = 2'd2;
            sb_q.push_back(e);
        end
        @(posedge clk); #2;
        start_i = 1'b0;
        if (disturb) begin
            // R10: extra start and altered operands mid-session
            repeat (30) @(posedge clk);
            #2;
            start_i = 1'b1; key_i = ~key; frame_i = ~frame;
            @(posedge clk); #2;
            start_i = 1'b0;
            repeat (200) @(posedge clk);
            #2;
            start_i = 1'b1;
            @(posedge clk); #2;
            start_i = 1'b0;
        end
        wait (sb_q.size() == 0);
    endtask

    initial begin
        #1600000;
        total++; bad++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        // R1: reset state
        #6;
        check_vec("R1", {125'd0, ctrl}, 128'd0);
        check_vec("R1", {127'd0, busy}, 128'd0);
        check_vec("R1", {127'd0, done}, 128'd0);
        check_vec("R1", {14'd0, word_a}, 128'd0);
        @(posedge clk); #2;
        rst_n = 1'b1;

        run_session(64'hEFCDAB8967452312, 22'h000134, 1'b0);
        run_session(64'hFFFFFFFFFFFFFFFF, 22'h3FFFFF, 1'b0);
        run_session(64'h8000000000000001, 22'h200001, 1'b1);

        // R1: reset in the middle of a session
        @(posedge clk); #2;
        start_i = 1'b1; key_i = 64'h0123456789ABCDEF;
        @(posedge clk); #2;
        start_i = 1'b0;
        repeat (80) @(posedge clk);
        #2;
        rst_n = 1'b0;
        @(negedge clk);
        check_vec("R1", {125'd0, ctrl}, 128'd0);
        check_vec("R1", {127'd0, busy}, 128'd0);
        check_vec("R1", {127'd0, done}, 128'd0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        @(negedge clk);
        check_vec("R1", {127'd0, busy}, 128'd0);

        run_session(64'h5A5A0F0F3C3CA5A5, 22'h15AA55, 1'b0);

        repeat (3) @(posedge clk);
        report();
        $finish;
    end
endmodule